// File: doc/BRIEF.md
# Low-Frequency Fallback Clock Generator

This block produces the core clock and the primary bus clock for a chip that can drop into a slow fallback mode. In normal operation the core clock comes from a fast PLL clock. When software sets a single mode bit, the block moves the core clock onto a slow clock. The slow clock is the reference clock divided by a power of two, and a 4-bit exponent sets that power. While the slow clock drives the output, the block asks the PLL to go into bypass so that it can save power.

A free-running counter, clocked directly by the reference clock, builds the slow clock. An exponent of zero passes the reference clock through undivided. Software may rewrite the exponent at any time. A new value is taken up only at the end of a full output period, so no shortened high or low phase appears.

The move between the two sources is a handshake through two synchronising flops on each side. The outgoing clock is switched off while it is low, and only then is the incoming clock switched on. The bus clock always runs at half the core clock, whichever source is in use.

Top module: `lowfreq_clkgen`

## Requirements
- R1: While rst_n is low, core_clk, bus_clk, src_is_slow and pll_bypass_req are all 0.
- R2: With fallback_en at 0 and the PLL source selected, core_clk follows pll_clk.
- R3: pll_bypass_req is 1 only while the divided source drives core_clk and fallback_en is 1. It is still 0 right after fallback_en rises. It falls as soon as fallback_en is cleared.
- R4: A new div_exp value is applied at the end of a full output period. The high phase in progress finishes at its old width, and the following phases use the new width.
- R5: The two clock gates are never open at the same time. No core_clk phase is shorter than half the period of the faster of the two sources involved in the handover.
- R6: div_exp is an unsigned 4-bit exponent n. In the divided mode, core_clk has a period of 2^n reference periods with a 50% duty cycle, and n = 0 passes ref_clk through unchanged.
- R7: bus_clk toggles on every rising edge of core_clk, so it runs at exactly half the core_clk rate in both modes.
- R8: Rewriting div_exp while the divided source is active never produces a core_clk phase shorter than half a reference period.
- R9: src_is_slow is 1 exactly while the divided source's gate is open. After fallback_en is cleared it stays 1 until the handover back to the PLL completes, and then it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the divider counter |
| pll_clk | input | 1 | Fast PLL clock used in normal mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| fallback_en | input | 1 | Mode bit, synchronous to ref_clk; 1 selects the divided clock |
| div_exp | input | 4 | Divide exponent n; divided clock is ref_clk / 2^n |
| core_clk | output | 1 | Glitch-free core clock |
| bus_clk | output | 1 | Primary bus clock, half the core_clk rate |
| pll_bypass_req | output | 1 | Asks the PLL to go into bypass / power down |
| src_is_slow | output | 1 | 1 while the divided clock drives core_clk |

## Verification
Two functions can land in the same reference cycle: an exponent commit in the divider and the start of the source handover. The bench provokes this by rewriting div_exp on the very edge where fallback_en rises. An edge monitor then records every core_clk high and low width across the window. The result is judged on the narrowest phase seen, and on the period that the output settles to afterwards.

// File: rtl/lfclk_pkg.sv
`timescale 1ns/1ps
package lfclk_pkg;
    // default exponent width: ratios 2^0 .. 2^15
    parameter int unsigned EXP_W_DFLT = 4;
    // synchronising flops per side of the source handover
    parameter int unsigned SYNC_DFLT  = 2;

    typedef enum logic {
        SRC_PLL = 1'b0,
        SRC_DIV = 1'b1
    } clk_src_e;
endpackage

// File: rtl/lfclk_ref_divider.sv
`timescale 1ns/1ps
module lfclk_ref_divider
    import lfclk_pkg::*;
#(
    parameter int unsigned EXP_W = EXP_W_DFLT
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_req,
    output logic             div_clk,
    output logic [EXP_W-1:0] exp_cur,
    output logic             div_half
);
    localparam int unsigned CNT_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] expo;
        logic             half;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             at_edge;
    logic             pass_d, pass_q;

    // next state: counter, active exponent, registered half-rate output
    always_comb begin
        st_d    = st_q;
        mask    = (CNT_W'(1) << st_q.expo) - CNT_W'(1);
        at_edge = &(st_q.cnt | ~mask);
        if (at_edge) begin
            // end of a full output period: everything low, adopt new exponent
            st_d.cnt  = '0;
            st_d.expo = exp_req;
            st_d.half = 1'b0;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.half = (st_q.expo == '0) ? 1'b0
                                          : st_d.cnt[st_q.expo - EXP_W'(1)];
        end
        // pass-through gate follows the active exponent, updated while ref low
        pass_d = (st_q.expo == '0);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= pass_d;
    end

    assign div_clk  = (ref_clk & pass_q) | st_q.half;
    assign exp_cur  = st_q.expo;
    assign div_half = st_q.half;
endmodule

// File: rtl/lfclk_gate_sync.sv
`timescale 1ns/1ps
module lfclk_gate_sync
    import lfclk_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DFLT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic en
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], req};
    end

    // falling-edge flops: the gate only changes while its clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.sh[STAGES-1];
endmodule

// File: rtl/lfclk_half_rate.sv
`timescale 1ns/1ps
module lfclk_half_rate (
    input  logic clk,
    input  logic rst_n,
    output logic half_clk
);
    typedef struct packed {
        logic tog;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_clk = st_q.tog;
endmodule

// File: rtl/lowfreq_clkgen.sv
`timescale 1ns/1ps
module lowfreq_clkgen
    import lfclk_pkg::*;
#(
    parameter int unsigned EXP_W       = EXP_W_DFLT,
    parameter int unsigned SYNC_STAGES = SYNC_DFLT
) (
    input  logic             ref_clk,
    input  logic             pll_clk,
    input  logic             rst_n,
    input  logic             fallback_en,
    input  logic [EXP_W-1:0] div_exp,
    output logic             core_clk,
    output logic             bus_clk,
    output logic             pll_bypass_req,
    output logic             src_is_slow
);
    logic             div_clk;
    logic [EXP_W-1:0] exp_cur;
    logic             div_half;
    logic             pll_on;
    logic             div_on;
    logic             pll_req;
    logic             div_req;
    clk_src_e         cur_src;

    lfclk_ref_divider #(.EXP_W(EXP_W)) u_div (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .exp_req  (div_exp),
        .div_clk  (div_clk),
        .exp_cur  (exp_cur),
        .div_half (div_half)
    );

    // each side asks for its gate only once the other side's gate is shut
    assign pll_req = !fallback_en && !div_on;
    assign div_req =  fallback_en && !pll_on;

    lfclk_gate_sync #(.STAGES(SYNC_STAGES)) u_pll_gate (
        .clk   (pll_clk),
        .rst_n (rst_n),
        .req   (pll_req),
        .en    (pll_on)
    );

    lfclk_gate_sync #(.STAGES(SYNC_STAGES)) u_div_gate (
        .clk   (div_clk),
        .rst_n (rst_n),
        .req   (div_req),
        .en    (div_on)
    );

    assign core_clk = (pll_clk & pll_on) | (div_clk & div_on);

    lfclk_half_rate u_bus (
        .clk      (core_clk),
        .rst_n    (rst_n),
        .half_clk (bus_clk)
    );

    assign cur_src        = div_on ? SRC_DIV : SRC_PLL;
    assign src_is_slow    = (cur_src == SRC_DIV);
    assign pll_bypass_req = src_is_slow && fallback_en;
endmodule

// File: rtl/lfclk_checks.sv
`timescale 1ns/1ps
module lfclk_checks #(
    parameter int unsigned EXP_W = 4
) (
    input logic             ref_clk,
    input logic             core_clk,
    input logic             rst_n,
    input logic             pll_on,
    input logic             div_on,
    input logic             div_half,
    input logic             bus_clk,
    input logic             pll_bypass_req,
    input logic [EXP_W-1:0] exp_cur
);
    // R5: both source gates never open together
    p_gates_exclusive_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(pll_on && div_on));

    // R3: bypass only requested once the PLL gate is shut
    p_bypass_pll_off_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pll_bypass_req |-> !pll_on);

    // R4: an exponent commit happens right after a completed high phase
    p_commit_after_high_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (exp_cur != $past(exp_cur)) && ($past(exp_cur) != '0) |-> $past(div_half));

    // R8: a committed exponent starts its period from a low output
    p_commit_low_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (exp_cur != $past(exp_cur)) |-> !div_half);

    // R6: in pass-through the registered half-rate path stays low
    p_pass_quiet_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (exp_cur == '0) |-> !div_half);

    // R7: bus clock toggles on each core rising edge
    p_bus_fall_r7: assert property (@(posedge core_clk) disable iff (!rst_n)
        bus_clk |=> !bus_clk);
    p_bus_rise_r7: assert property (@(posedge core_clk) disable iff (!rst_n)
        !bus_clk |=> bus_clk);
endmodule

bind lowfreq_clkgen lfclk_checks #(.EXP_W(EXP_W)) u_checks (
    .ref_clk        (ref_clk),
    .core_clk       (core_clk),
    .rst_n          (rst_n),
    .pll_on         (pll_on),
    .div_on         (div_on),
    .div_half       (div_half),
    .bus_clk        (bus_clk),
    .pll_bypass_req (pll_bypass_req),
    .exp_cur        (exp_cur)
);

// File: tb/lowfreq_clkgen_test.sv
`timescale 1ns/1ps
module lowfreq_clkgen_test;
    logic       ref_clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       fallback_en = 1'b0;
    logic [3:0] div_exp = 4'd2;
    logic       core_clk, bus_clk, pll_bypass_req, src_is_slow;

    int checks = 0;
    int errors = 0;

    // ref clock: 100 MHz; PLL clock: 250 MHz
    always #5 ref_clk = ~ref_clk;
    always #2 pll_clk = ~pll_clk;

    lowfreq_clkgen uut (
        .ref_clk        (ref_clk),
        .pll_clk        (pll_clk),
        .rst_n          (rst_n),
        .fallback_en    (fallback_en),
        .div_exp        (div_exp),
        .core_clk       (core_clk),
        .bus_clk        (bus_clk),
        .pll_bypass_req (pll_bypass_req),
        .src_is_slow    (src_is_slow)
    );

    // edge monitor: narrowest core_clk phase since the last epoch bump
    int      mon_epoch = 0;
    int      seen_epoch = 0;
    bit      have_last = 1'b0;
    realtime last_edge = 0.0;
    realtime min_w = 1.0e9;

    always @(core_clk) begin
        if (seen_epoch != mon_epoch) begin
            seen_epoch = mon_epoch;
            have_last  = 1'b0;
            min_w      = 1.0e9;
        end
        if (have_last && (($realtime - last_edge) < min_w))
            min_w = $realtime - last_edge;
        last_edge = $realtime;
        have_last = 1'b1;
    end

    task automatic restart_monitor();
        mon_epoch++;
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_time(string tag, realtime act, realtime exp);
        checks++;
        if ((act - exp > 0.01) || (exp - act > 0.01)) begin
            errors++;
            $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
        end
    endtask

    task automatic chk_min(string tag, realtime act, realtime floor_w);
        checks++;
        if (act < floor_w - 0.01) begin
            errors++;
            $display("FAIL %s: actual %0.3f expected >= %0.3f", tag, act, floor_w);
        end
    endtask

    // one full core period: high width then low width
    task automatic measure_core(output realtime hi, output realtime lo);
        realtime t0, t1, t2;
        @(posedge core_clk); t0 = $realtime;
        @(negedge core_clk); t1 = $realtime;
        @(posedge core_clk); t2 = $realtime;
        hi = t1 - t0;
        lo = t2 - t1;
    endtask

    task automatic measure_bus(output realtime per);
        realtime t0;
        @(posedge bus_clk); t0 = $realtime;
        @(posedge bus_clk); per = $realtime - t0;
    endtask

    task automatic wait_src(logic v);
        for (int i = 0; i < 4000; i++) begin
            if (src_is_slow == v) break;
            @(negedge ref_clk);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge core_clk);
    endtask

    task automatic t_reset();
        #50;
        chk_bit("R1 core_clk in reset", core_clk, 1'b0);
        chk_bit("R1 bus_clk in reset", bus_clk, 1'b0);
        chk_bit("R1 src_is_slow in reset", src_is_slow, 1'b0);
        chk_bit("R1 bypass in reset", pll_bypass_req, 1'b0);
        #3 rst_n = 1'b1;
        #100;
    endtask

    task automatic t_pll_mode();
        realtime hi, lo, per;
        measure_core(hi, lo);
        chk_time("R2 pll high width", hi, 2.0);
        chk_time("R2 pll low width", lo, 2.0);
        measure_bus(per);
        chk_time("R7 bus period pll mode", per, 8.0);
        chk_bit("R9 status on pll", src_is_slow, 1'b0);
    endtask

    task automatic t_enter_slow();
        realtime hi, lo, per;
        restart_monitor();
        @(negedge ref_clk);
        div_exp     = 4'd2;
        fallback_en = 1'b1;
        #1;
        chk_bit("R3 no bypass before handover", pll_bypass_req, 1'b0);
        wait_src(1'b1);
        chk_bit("R9 status after handover", src_is_slow, 1'b1);
        chk_bit("R3 bypass while divided", pll_bypass_req, 1'b1);
        settle(2);
        chk_min("R5 narrowest phase entering", min_w, 2.0);
        measure_core(hi, lo);
        chk_time("R6 n=2 high width", hi, 20.0);
        chk_time("R6 n=2 low width", lo, 20.0);
        measure_bus(per);
        chk_time("R7 bus period n=2", per, 80.0);
    endtask

    task automatic t_ratios();
        realtime hi, lo;
        div_exp = 4'd0;
        settle(4);
        measure_core(hi, lo);
        chk_time("R6 n=0 high width", hi, 5.0);
        chk_time("R6 n=0 low width", lo, 5.0);
        div_exp = 4'd4;
        settle(3);
        measure_core(hi, lo);
        chk_time("R6 n=4 high width", hi, 80.0);
        chk_time("R6 n=4 low width", lo, 80.0);
    endtask

    task automatic t_retune_down();
        realtime t0, t1, t2, t3;
        div_exp = 4'd3;
        settle(3);
        @(posedge core_clk); t0 = $realtime;
        #1 div_exp = 4'd1;
        @(negedge core_clk); t1 = $realtime;
        @(posedge core_clk); t2 = $realtime;
        @(negedge core_clk); t3 = $realtime;
        chk_time("R4 old high completes (3->1)", t1 - t0, 40.0);
        chk_time("R4 new low width (3->1)", t2 - t1, 10.0);
        chk_time("R4 new high width (3->1)", t3 - t2, 10.0);
    endtask

    task automatic t_retune_up();
        realtime t0, t1, t2, t3;
        settle(3);
        @(posedge core_clk); t0 = $realtime;
        #1 div_exp = 4'd3;
        @(negedge core_clk); t1 = $realtime;
        @(posedge core_clk); t2 = $realtime;
        @(negedge core_clk); t3 = $realtime;
        chk_time("R4 old high completes (1->3)", t1 - t0, 10.0);
        chk_time("R4 new low width (1->3)", t2 - t1, 40.0);
        chk_time("R4 new high width (1->3)", t3 - t2, 40.0);
    endtask

    task automatic t_sweep();
        restart_monitor();
        for (int i = 0; i < 12; i++) begin
            div_exp = 4'((i * 5 + 3) % 6);
            #(37 + i * 53);
        end
        settle(2);
        chk_min("R8 narrowest phase during retunes", min_w, 5.0);
    endtask

    task automatic t_exit();
        realtime hi, lo;
        restart_monitor();
        @(negedge ref_clk);
        fallback_en = 1'b0;
        #1;
        chk_bit("R3 bypass drops with mode bit", pll_bypass_req, 1'b0);
        chk_bit("R9 status held during handover", src_is_slow, 1'b1);
        wait_src(1'b0);
        chk_bit("R9 status back on pll", src_is_slow, 1'b0);
        settle(4);
        chk_min("R5 narrowest phase leaving", min_w, 2.0);
        measure_core(hi, lo);
        chk_time("R2 pll high after return", hi, 2.0);
        chk_time("R2 pll low after return", lo, 2.0);
    endtask

    // exponent commit and source handover in the same reference cycle
    task automatic t_collide();
        realtime hi, lo;
        div_exp = 4'd1;
        #200;
        restart_monitor();
        @(negedge ref_clk);
        fallback_en = 1'b1;
        div_exp     = 4'd3;
        wait_src(1'b1);
        settle(3);
        chk_min("R5 narrowest phase, commit during handover", min_w, 2.0);
        measure_core(hi, lo);
        chk_time("R4 period after collision (high)", hi, 40.0);
        chk_time("R4 period after collision (low)", lo, 40.0);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pll_mode();
        t_enter_slow();
        t_ratios();
        t_retune_down();
        t_retune_up();
        t_sweep();
        t_exit();
        t_collide();
        t_exit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule